// File: doc/BRIEF.md
# Sticky Diagnostic Status Registers

This block is the diagnostic register bank of an audio PWM controller. Software reads two views through a small register port. The first is a live general status word. It shows whether a volume ramp is running, whether every output channel is producing data, and whether any internal fault is present. It also carries a fixed 5-bit device identifier. The second view is a sticky error word. Each of its bits records a clock or timing fault pulse, or a change on one of two mode-select pins, and keeps that record until software clears it.

Clock checking, volume ramping and PWM generation sit in other blocks. This block only receives their single-cycle fault pulses and their live status levels. The two mode-select pins arrive asynchronously. Each pin passes through a synchronizer, and any change of its level, in either direction, is latched as an error. Checking of the pins is held off after reset until the synchronizer has settled, so a pin that is simply tied high does not raise a false event.

The expected use is as follows. Software brings the controller up, confirms that its clocks run, and clears the error word by writing zero to it. From then on, any nonzero bit in the error word marks a fault or a pin change that has occurred since that clear.

Top module: `pwm_diag_regs`

## Requirements
- R1: Bit 0 of the general status word (address 0) follows `vol_busy` in the same cycle. It is a live view, not a latch.
- R2: Bits 7:3 of the general status word always read the device identifier 5'b10011.
- R3: Bit 1 of the general status word (all-valid) is 1 only when every channel is valid. Channel i is invalid when any of these holds: `clk_err` is 1, `recover_n` is 0, `automute[i]` is 1, `mute` is 1, or `vol_full_att` is 1.
- R4: Bit 2 of the general status word (no-internal-error) equals `!clk_err && recover_n`.
- R5: In the error word (address 1), a fault pulse sets its bit on the next clock edge. The bit stays set until a clear. The bit positions are: 0 sample-rate, 2 frame clock, 3 master clock count, 4 PWM-clock phase, 5 master-clock phase, 6 PWM timing.
- R6: A level change in either direction on `role_sel_pin` or `rate_sel_pin` sets error bit 1 within 4 cycles of the change. A pin that holds a steady level sets nothing, including a pin that is high while reset is released.
- R7: A write of 8'h00 to address 1 clears the error word from the next cycle. A write of any nonzero value to address 1, and any write to address 0, leaves the error word unchanged.
- R8: If a fault pulse arrives in the same cycle as a clear write, its bit is set after that cycle. The new event is not lost.
- R9: After reset the error word reads 8'h00. Bit 7 of the error word always reads 0.
- R10: Reads of addresses 2 and 3 return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| vol_busy | input | 1 | A volume ramp or mute ramp is running |
| clk_err | input | 1 | A clock error is currently present |
| recover_n | input | 1 | Error recovery request, active low |
| automute | input | NUM_CH | Per-channel silence caused by zero input |
| mute | input | 1 | Mute is set |
| vol_full_att | input | 1 | Volume is at full attenuation |
| fs_err_p | input | 1 | Sample-rate fault pulse |
| frame_clk_err_p | input | 1 | Frame clock fault pulse |
| mstr_cnt_err_p | input | 1 | Master clock count fault pulse |
| pwmclk_phase_err_p | input | 1 | PWM clock vs master clock phase fault pulse |
| mstrclk_phase_err_p | input | 1 | Master clock vs PWM clock phase fault pulse |
| pwm_timing_err_p | input | 1 | PWM timing fault pulse |
| role_sel_pin | input | 1 | Asynchronous master/slave select pin |
| rate_sel_pin | input | 1 | Asynchronous double-rate select pin |

## Verification
The bench drives a clear write and a fault pulse in the same cycle. A design that gives the clear priority would drop the new event and read zero. Nonzero writes to the error address, and writes to the status address, are also tried. A design that clears on any write would lose bits that were set earlier. Mode pins are held high through reset release and must not raise the pin-change bit. A design without settling logic would report a false change. Each inactivation cause is also applied on its own, and random traffic with a fixed seed checks the live view against a model in the bench. A design that ignores one cause, or treats the status view as latched, would show the wrong all-valid bit.

// File: rtl/pwm_diag_pkg.sv
package pwm_diag_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int ERR_W    = 7;
  localparam int DEV_ID_W = 5;
  localparam logic [DEV_ID_W-1:0] DEV_ID = 5'b10011;

  localparam logic [ADDR_W-1:0] ADDR_GEN = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ERR = 2'd1;

  // error word bit positions (software decodes these)
  localparam int EB_FS    = 0;
  localparam int EB_PIN   = 1;
  localparam int EB_FRAME = 2;
  localparam int EB_MCNT  = 3;
  localparam int EB_PPH   = 4;
  localparam int EB_MPH   = 5;
  localparam int EB_PWM   = 6;

  typedef enum logic [1:0] {SEL_GEN, SEL_ERR, SEL_NONE} rd_sel_e;

  function automatic logic channel_ok(input logic clk_bad, input logic recov_n,
                                      input logic amuted, input logic muted,
                                      input logic full_att);
    return !clk_bad && recov_n && !amuted && !muted && !full_att;
  endfunction

  function automatic logic [DATA_W-1:0] pack_general(input logic busy,
                                                     input logic all_ok,
                                                     input logic no_int);
    return {DEV_ID, no_int, all_ok, busy};
  endfunction

  function automatic logic [DATA_W-1:0] pack_error(input logic [ERR_W-1:0] e);
    return {{(DATA_W-ERR_W){1'b0}}, e};
  endfunction

  function automatic rd_sel_e decode_read(input logic [ADDR_W-1:0] a);
    if (a == ADDR_GEN) return SEL_GEN;
    if (a == ADDR_ERR) return SEL_ERR;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/pwm_diag_pin_watch.sv
module pwm_diag_pin_watch #(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_async,
  output logic                change_o
);
  localparam int PRIME = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(PRIME + 1);

  logic [CNT_W-1:0]    settle_cnt;
  logic                primed;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_prev;
  logic [NUM_PINS-1:0] pin_chg;

  assign primed = (settle_cnt == CNT_W'(PRIME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       settle_cnt <= '0;
    else if (!primed) settle_cnt <= settle_cnt + 1'b1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain       <= '0;
        pin_prev[p] <= 1'b0;
      end else begin
        chain       <= {chain[SYNC_STAGES-2:0], pins_async[p]};
        pin_prev[p] <= chain[SYNC_STAGES-1];
      end
    end
    assign pin_sync[p] = chain[SYNC_STAGES-1];
    assign pin_chg[p]  = primed && (pin_sync[p] != pin_prev[p]);
  end

  assign change_o = |pin_chg;
endmodule

// File: rtl/pwm_diag_valid_agg.sv
module pwm_diag_valid_agg
  import pwm_diag_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk_err,
  input  logic              recover_n,
  input  logic [NUM_CH-1:0] automute,
  input  logic              mute,
  input  logic              vol_full_att,
  output logic              all_valid,
  output logic              no_int_err
);
  logic [NUM_CH-1:0] ch_valid;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_valid[c] = channel_ok(clk_err, recover_n, automute[c], mute, vol_full_att);
  end

  assign all_valid  = &ch_valid;
  assign no_int_err = !clk_err && recover_n;
endmodule

// File: rtl/pwm_diag_sticky.sv
module pwm_diag_sticky #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[b] <= 1'b0;
      else        q[b] <= set_i[b] | (q[b] & ~clr_i);
    end
  end
endmodule

// File: rtl/pwm_diag_regs.sv
module pwm_diag_regs
  import pwm_diag_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vol_busy,
  input  logic              clk_err,
  input  logic              recover_n,
  input  logic [NUM_CH-1:0] automute,
  input  logic              mute,
  input  logic              vol_full_att,
  input  logic              fs_err_p,
  input  logic              frame_clk_err_p,
  input  logic              mstr_cnt_err_p,
  input  logic              pwmclk_phase_err_p,
  input  logic              mstrclk_phase_err_p,
  input  logic              pwm_timing_err_p,
  input  logic              role_sel_pin,
  input  logic              rate_sel_pin
);
  logic             clr_evt;
  logic             pin_chg_evt;
  logic [ERR_W-1:0] fault_vec;
  logic [ERR_W-1:0] err_q;
  logic             all_valid;
  logic             no_int_err;
  rd_sel_e          rd_sel;

  // only an all-zero write to the error address clears it
  assign clr_evt = reg_wr && (reg_addr == ADDR_ERR) && (reg_wdata == '0);

  pwm_diag_pin_watch #(.NUM_PINS(2), .SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_async({rate_sel_pin, role_sel_pin}),
    .change_o  (pin_chg_evt)
  );

  always_comb begin
    fault_vec           = '0;
    fault_vec[EB_FS]    = fs_err_p;
    fault_vec[EB_PIN]   = pin_chg_evt;
    fault_vec[EB_FRAME] = frame_clk_err_p;
    fault_vec[EB_MCNT]  = mstr_cnt_err_p;
    fault_vec[EB_PPH]   = pwmclk_phase_err_p;
    fault_vec[EB_MPH]   = mstrclk_phase_err_p;
    fault_vec[EB_PWM]   = pwm_timing_err_p;
  end

  pwm_diag_sticky #(.W(ERR_W)) u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(fault_vec),
    .clr_i(clr_evt),
    .q    (err_q)
  );

  pwm_diag_valid_agg #(.NUM_CH(NUM_CH)) u_valid (
    .clk_err     (clk_err),
    .recover_n   (recover_n),
    .automute    (automute),
    .mute        (mute),
    .vol_full_att(vol_full_att),
    .all_valid   (all_valid),
    .no_int_err  (no_int_err)
  );

  assign rd_sel = decode_read(reg_addr);

  always_comb begin
    case (rd_sel)
      SEL_GEN: reg_rdata = pack_general(vol_busy, all_valid, no_int_err);
      SEL_ERR: reg_rdata = pack_error(err_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_diag_regs_chk.sv
module pwm_diag_regs_chk
  import pwm_diag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              clr_evt,
  input logic              pin_chg_evt,
  input logic [ERR_W-1:0]  fault_vec,
  input logic [ERR_W-1:0]  err_q,
  input logic              mute,
  input logic              recover_n
);
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_vec) |=> ((err_q & $past(fault_vec)) == $past(fault_vec)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt) |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && (fault_vec == '0)) |=> (err_q == '0));

  assert_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && (|fault_vec)) |=> (err_q == $past(fault_vec)));

  assert_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg_evt |=> err_q[EB_PIN]);

  assert_devid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_GEN) |-> (reg_rdata[7:3] == 5'b10011));

  assert_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADDR_GEN) && (mute || !recover_n)) |-> !reg_rdata[1]);

  assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_ERR) |-> !reg_rdata[7]);
endmodule

bind pwm_diag_regs pwm_diag_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .clr_evt    (clr_evt),
  .pin_chg_evt(pin_chg_evt),
  .fault_vec  (fault_vec),
  .err_q      (err_q),
  .mute       (mute),
  .recover_n  (recover_n)
);

// File: tb/pwm_diag_regs_tb.sv
module pwm_diag_regs_tb;
  localparam int NCH = 6;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           reg_wr = 0;
  logic [1:0]     reg_addr = 0;
  logic [7:0]     reg_wdata = 0;
  logic [7:0]     reg_rdata;
  logic           vol_busy = 0, clk_err = 0, recover_n = 1, mute = 0, vol_full_att = 0;
  logic [NCH-1:0] automute = 0;
  logic           fs_p = 0, frame_p = 0, mcnt_p = 0, pph_p = 0, mph_p = 0, pwm_p = 0;
  logic           role_pin = 1, rate_pin = 1;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  logic [6:0] exp_err = 0;

  always #5 clk = ~clk;

  pwm_diag_regs #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vol_busy(vol_busy),
    .clk_err(clk_err), .recover_n(recover_n), .automute(automute), .mute(mute),
    .vol_full_att(vol_full_att), .fs_err_p(fs_p), .frame_clk_err_p(frame_p),
    .mstr_cnt_err_p(mcnt_p), .pwmclk_phase_err_p(pph_p),
    .mstrclk_phase_err_p(mph_p), .pwm_timing_err_p(pwm_p),
    .role_sel_pin(role_pin), .rate_sel_pin(rate_pin)
  );

  // bench view of the general word
  function automatic logic [7:0] tb_general();
    logic ok = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (automute[c]) ok = 1'b0;
    if (clk_err || !recover_n || mute || vol_full_att) ok = 1'b0;
    return {5'h13, (recover_n & ~clk_err), ok, vol_busy};
  endfunction

  function automatic logic [6:0] tb_faults();
    return {pwm_p, mph_p, pph_p, mcnt_p, frame_p, 1'b0, fs_p};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic quiet();
    reg_wr = 0; reg_wdata = 0;
    {fs_p, frame_p, mcnt_p, pph_p, mph_p, pwm_p} = '0;
  endtask

  task automatic read_at(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); quiet(); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  // one cycle of stimulus, taken on the next rising edge
  task automatic one_cycle(input logic wr, input logic [1:0] a, input logic [7:0] d,
                           input logic [6:0] f);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    {pwm_p, mph_p, pph_p, mcnt_p, frame_p} = f[6:2];
    fs_p = f[0];
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); quiet(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // reset state, pins held high through reset
    repeat (3) @(negedge clk);
    reg_addr = 1; #1;
    check("R9 error word in reset", reg_rdata, 8'h00);
    reg_addr = 0; #1;
    check("R2 R3 R4 general in reset", reg_rdata, tb_general());
    @(negedge clk); rst_n = 1;
    idle(6);
    read_at(1, 8'h00, "R6 steady high pins at reset release");
    read_at(1, 8'h00, "R9 error word after reset");

    // pin changes
    @(negedge clk); role_pin = 0;
    idle(5);
    read_at(1, 8'h02, "R6 role pin falling");
    one_cycle(1, 1, 8'h00, 7'h00);
    read_at(1, 8'h00, "R7 clear after role change");
    @(negedge clk); rate_pin = 0;
    idle(5);
    read_at(1, 8'h02, "R6 rate pin falling");
    one_cycle(1, 1, 8'h00, 7'h00);
    @(negedge clk); rate_pin = 1;
    idle(5);
    read_at(1, 8'h02, "R6 rate pin rising");
    one_cycle(1, 1, 8'h00, 7'h00);
    idle(6);
    read_at(1, 8'h00, "R6 no event while pins steady");

    // each fault on its own
    for (int b = 0; b < 7; b++) begin
      if (b == 1) continue;
      one_cycle(0, 1, 8'h00, 7'(1 << b));
      read_at(1, 8'(1 << b), $sformatf("R5 fault bit %0d set", b));
      idle(3);
      read_at(1, 8'(1 << b), $sformatf("R5 fault bit %0d held", b));
      one_cycle(1, 1, 8'h00, 7'h00);
      read_at(1, 8'h00, "R7 clear single fault");
    end

    // writes that must not clear
    one_cycle(0, 1, 8'h00, 7'h41);
    one_cycle(1, 1, 8'h55, 7'h00);
    read_at(1, 8'h41, "R7 nonzero write ignored");
    one_cycle(1, 0, 8'h00, 7'h00);
    read_at(1, 8'h41, "R7 write to status address ignored");
    one_cycle(1, 1, 8'h00, 7'h00);
    read_at(1, 8'h00, "R7 zero write clears");

    // clear and event in the same cycle
    one_cycle(0, 1, 8'h00, 7'h08);
    one_cycle(1, 1, 8'h00, 7'h04);
    read_at(1, 8'h04, "R8 event kept across simultaneous clear");
    one_cycle(1, 1, 8'h00, 7'h00);

    // each inactivation cause alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); quiet(); reg_addr = 0;
      clk_err = (k == 0); recover_n = (k != 1); mute = (k == 2);
      vol_full_att = (k == 3); automute = (k == 4) ? NCH'(1 << (NCH - 1)) : '0;
      vol_busy = (k == 5); #1;
      check($sformatf("R1 R3 R4 cause %0d", k), reg_rdata, tb_general());
    end
    read_at(2, 8'h00, "R10 address 2");
    read_at(3, 8'h00, "R10 address 3");

    // random traffic against the bench model
    exp_err = 0;
    for (int it = 0; it < 3000; it++) begin
      logic [6:0] f;
      @(negedge clk);
      vol_busy = $urandom_range(0, 1);
      clk_err = ($urandom_range(0, 7) == 0);
      recover_n = ($urandom_range(0, 7) != 0);
      mute = ($urandom_range(0, 7) == 0);
      vol_full_att = ($urandom_range(0, 7) == 0);
      for (int c = 0; c < NCH; c++) automute[c] = ($urandom_range(0, 15) == 0);
      reg_addr = 2'($urandom_range(0, 3));
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_wdata = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      f = 0;
      for (int b = 0; b < 7; b++) if (b != 1) f[b] = ($urandom_range(0, 15) == 0);
      {pwm_p, mph_p, pph_p, mcnt_p, frame_p} = f[6:2];
      fs_p = f[0];
      #1;
      case (reg_addr)
        2'd0:    check("R1 R2 R3 R4 random general", reg_rdata, tb_general());
        2'd1:    check("R5 R7 R8 R9 random error", reg_rdata, {1'b0, exp_err});
        default: check("R10 random unused address", reg_rdata, 8'h00);
      endcase
      @(posedge clk);
      if (reg_wr && reg_addr == 2'd1 && reg_wdata == 8'h00) exp_err = 0;
      exp_err = exp_err | tb_faults();
    end
    read_at(1, {1'b0, exp_err}, "R5 final error word");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule